// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central bookkeeping unit of a processor core whose functional units may finish out of order. Each cycle it is offered at most one decoded instruction (operation, destination register, two source registers and a unit class). It decides whether the instruction may enter a functional-unit slot. It tells each slot when its operands may be read from the register file and when its result may be written back. Each slot answers with a one-cycle `exec_done` pulse when its arithmetic is finished.

Internally the controller keeps a status record per slot and a result-owner entry per architectural register. With these it enforces four rules. A busy slot blocks issue (structural). A pending writer of the same destination blocks issue (write-after-write). An operand read waits until the producing slot has written (read-after-write). A write waits while another slot still has to read the old value of that register (write-after-read). Instructions enter strictly in program order. Reads and writes may then happen in any order across slots. The register file, the arithmetic and exception handling live outside the block.

Top module: `sb_hazard_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every slot is free, no register has a pending writer, `rd_grant` and `wr_grant` are all zero, and an instruction offered next is accepted.
- R2: Class codes map to slots as follows: class 0 (integer) to slot 0, class 1 (multiply) to slot 1, or to slot 2 when slot 1 is taken, class 2 (add) to slot 3, and class 3 (divide) to slot 4. `iss_unit` shows the chosen free slot, or 7 when no slot of the class is free. In that case `iss_accept` stays low.
- R3: `iss_accept` is high only when `iss_valid` is high, a slot of the class is free, and no slot still has to write the destination register. A refused instruction changes no state, and the source must keep offering it.
- R4: An accepted instruction records, for each source, the slot that still has to write that register. A source with no pending writer is marked ready at once.
- R5: A slot gets `rd_grant` in the cycle after issue when both sources are ready. Otherwise it gets it in the cycle after the last producing slot's write grant.
- R6: `rd_grant` lasts one cycle per issued instruction. Slots may read in an order different from their issue order.
- R7: `exec_done` is ignored unless the slot has read its operands and is not yet finished. The earliest `wr_grant` is the cycle after the accepted `exec_done`.
- R8: A finished slot is refused `wr_grant` while another busy slot has a ready, unread source equal to its destination. It is granted in the cycle after that reader's `rd_grant`.
- R9: At most one `wr_grant` bit is high per cycle, and the lowest-numbered eligible slot wins. `wr_dst` carries the destination of the granted slot, and the slot is free afterwards.
- R10: In the cycle of a write, issue sees the state after that write. A register being written counts as having no pending writer, a source equal to it is ready, and the slot being written counts as free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| iss_valid | input | 1 | An instruction is offered this cycle |
| iss_op | input | OP_W | Operation code, stored for the slot |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_class | input | 2 | Unit class: 0 integer, 1 multiply, 2 add, 3 divide |
| iss_accept | output | 1 | The offered instruction enters a slot at this edge |
| iss_unit | output | 3 | Slot chosen for the offered class, 7 when none is free |
| rd_grant | output | 5 | Per slot: read operands this cycle |
| exec_done | input | 5 | Per slot: execution finished (pulse) |
| wr_grant | output | 5 | Per slot: write the result this cycle |
| wr_dst | output | REG_W | Register written under `wr_grant` |
| unit_op | output | 5*OP_W | Operation held by each slot, slot 0 in the low bits |

## Verification
The interesting collisions are a result write and an issue that touches the same register or slot in the same cycle. In that case the issuing instruction must see the state after the write. A directed sequence holds a write-after-write victim at the issue port until its blocker is granted the write. It then swaps in a reader of that register in the write cycle and expects acceptance plus a read grant one cycle later. The second collision is two slots finishing together. The bench expects the lower slot first and the other one cycle later. Random traffic over a small register range keeps all these overlaps common, and each cycle is compared against a bench-side reference model.

// File: rtl/sb_pkg.sv
// Package: shared constants and types for the scoreboard hazard controller.
// Assumes exactly five slots: integer, two multipliers, add, divide.
package sb_pkg;
    localparam int NUM_UNITS = 5;
    localparam int UNIT_W    = 3;
    localparam int CLASS_W   = 2;

    localparam logic [UNIT_W-1:0] UNIT_NONE = 3'd7;
    localparam logic [UNIT_W-1:0] SLOT_INT  = 3'd0;
    localparam logic [UNIT_W-1:0] SLOT_MUL1 = 3'd1;
    localparam logic [UNIT_W-1:0] SLOT_MUL2 = 3'd2;
    localparam logic [UNIT_W-1:0] SLOT_ADD  = 3'd3;
    localparam logic [UNIT_W-1:0] SLOT_DIV  = 3'd4;

    localparam logic [CLASS_W-1:0] CLS_INT = 2'd0;
    localparam logic [CLASS_W-1:0] CLS_MUL = 2'd1;
    localparam logic [CLASS_W-1:0] CLS_ADD = 2'd2;
    localparam logic [CLASS_W-1:0] CLS_DIV = 2'd3;

    // Life cycle of one slot.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_EXEC = 2'd2,
        PH_DONE = 2'd3
    } phase_t;
endpackage

// File: rtl/sb_reg_status.sv
// Register result-owner table: one slot code per register, UNIT_NONE when free.
// Lookups return the view after this cycle's write, so issue sees post-write state.
// Assumes at most one write per cycle and that a register has at most one owner.
module sb_reg_status
    import sb_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [REG_W-1:0]  wr_dst,
    input  logic              iss_fire,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [UNIT_W-1:0] iss_unit,
    input  logic [REG_W-1:0]  look_a,
    input  logic [REG_W-1:0]  look_b,
    input  logic [REG_W-1:0]  look_d,
    output logic [UNIT_W-1:0] owner_a,
    output logic [UNIT_W-1:0] owner_b,
    output logic              dst_pending
);
    localparam int NUM_REGS = 1 << REG_W;

    logic [UNIT_W-1:0] owner [NUM_REGS];

    // Post-write owner lookups for both sources and the destination.
    assign owner_a     = (wr_fire && wr_dst == look_a) ? UNIT_NONE : owner[look_a];
    assign owner_b     = (wr_fire && wr_dst == look_b) ? UNIT_NONE : owner[look_b];
    assign dst_pending = !(wr_fire && wr_dst == look_d) && (owner[look_d] != UNIT_NONE);

    // Release on write, then claim on issue (a claim of the same register wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) owner[r] <= UNIT_NONE;
        end else begin
            if (wr_fire)  owner[wr_dst]  <= UNIT_NONE;
            if (iss_fire) owner[iss_dst] <= iss_unit;
        end
    end
endmodule

// File: rtl/sb_issue_sel.sv
// Issue decision: picks the slot for the offered class and checks the
// structural and write-after-write conditions. Pure combinational.
// Assumes slot_busy already excludes the slot being written this cycle.
module sb_issue_sel
    import sb_pkg::*;
(
    input  logic                 iss_valid,
    input  logic [CLASS_W-1:0]   iss_class,
    input  logic [NUM_UNITS-1:0] slot_busy,
    input  logic                 dst_pending,
    output logic [UNIT_W-1:0]    slot,
    output logic                 accept
);
    // Map class to a free slot; the second multiplier is the fallback.
    always_comb begin
        unique case (iss_class)
            CLS_INT: slot = slot_busy[SLOT_INT] ? UNIT_NONE : SLOT_INT;
            CLS_MUL: slot = !slot_busy[SLOT_MUL1] ? SLOT_MUL1 :
                            (!slot_busy[SLOT_MUL2] ? SLOT_MUL2 : UNIT_NONE);
            CLS_ADD: slot = slot_busy[SLOT_ADD] ? UNIT_NONE : SLOT_ADD;
            CLS_DIV: slot = slot_busy[SLOT_DIV] ? UNIT_NONE : SLOT_DIV;
            default: slot = UNIT_NONE;
        endcase
    end

    // Accept only with a free slot and no other writer of the destination.
    assign accept = iss_valid && (slot != UNIT_NONE) && !dst_pending;
endmodule

// File: rtl/sb_unit_table.sv
// Per-slot status records: phase, operation, destination, sources,
// producing slots and ready flags. Generates one record per slot.
// Assumes an issue only targets a slot that is free after this cycle's write.
module sb_unit_table
    import sb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int OP_W  = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            iss_fire,
    input  logic [UNIT_W-1:0]               iss_unit,
    input  logic [OP_W-1:0]                 iss_op,
    input  logic [REG_W-1:0]                iss_dst,
    input  logic [REG_W-1:0]                iss_src1,
    input  logic [REG_W-1:0]                iss_src2,
    input  logic [UNIT_W-1:0]               iss_qj,
    input  logic [UNIT_W-1:0]               iss_qk,
    input  logic [NUM_UNITS-1:0]            exec_done,
    input  logic                            wr_fire,
    input  logic [UNIT_W-1:0]               wr_unit,
    output logic [NUM_UNITS-1:0]            busy,
    output logic [NUM_UNITS-1:0]            rd_grant,
    output logic [NUM_UNITS-1:0]            done,
    output logic [NUM_UNITS-1:0]            rj,
    output logic [NUM_UNITS-1:0]            rk,
    output logic [NUM_UNITS-1:0][REG_W-1:0] fi,
    output logic [NUM_UNITS-1:0][REG_W-1:0] fj,
    output logic [NUM_UNITS-1:0][REG_W-1:0] fk,
    output logic [NUM_UNITS-1:0][OP_W-1:0]  op
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_slot
        localparam logic [UNIT_W-1:0] MY_CODE = UNIT_W'(u);

        phase_t            ph;
        logic [OP_W-1:0]   op_q;
        logic [REG_W-1:0]  fi_q, fj_q, fk_q;
        logic [UNIT_W-1:0] qj_q, qk_q;
        logic              rj_q, rk_q;
        logic              take_iss, take_wr, grant;

        assign take_iss = iss_fire && (iss_unit == MY_CODE);
        assign take_wr  = wr_fire && (wr_unit == MY_CODE);
        assign grant    = (ph == PH_WAIT) && rj_q && rk_q;

        // Advance the slot record: write release, wake-up, read, finish, issue.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph   <= PH_IDLE;
                op_q <= '0;
                fi_q <= '0;
                fj_q <= '0;
                fk_q <= '0;
                qj_q <= UNIT_NONE;
                qk_q <= UNIT_NONE;
                rj_q <= 1'b0;
                rk_q <= 1'b0;
            end else begin
                if (take_wr) begin
                    ph   <= PH_IDLE;
                    qj_q <= UNIT_NONE;
                    qk_q <= UNIT_NONE;
                    rj_q <= 1'b0;
                    rk_q <= 1'b0;
                end else begin
                    if (wr_fire && qj_q == wr_unit) begin
                        qj_q <= UNIT_NONE;
                        rj_q <= 1'b1;
                    end
                    if (wr_fire && qk_q == wr_unit) begin
                        qk_q <= UNIT_NONE;
                        rk_q <= 1'b1;
                    end
                    if (grant) begin
                        rj_q <= 1'b0;
                        rk_q <= 1'b0;
                        ph   <= PH_EXEC;
                    end else if (ph == PH_EXEC && exec_done[u]) begin
                        ph <= PH_DONE;
                    end
                end
                if (take_iss) begin
                    ph   <= PH_WAIT;
                    op_q <= iss_op;
                    fi_q <= iss_dst;
                    fj_q <= iss_src1;
                    fk_q <= iss_src2;
                    qj_q <= iss_qj;
                    qk_q <= iss_qk;
                    rj_q <= (iss_qj == UNIT_NONE);
                    rk_q <= (iss_qk == UNIT_NONE);
                end
            end
        end

        assign busy[u]     = (ph != PH_IDLE);
        assign rd_grant[u] = grant;
        assign done[u]     = (ph == PH_DONE);
        assign rj[u]       = rj_q;
        assign rk[u]       = rk_q;
        assign fi[u]       = fi_q;
        assign fj[u]       = fj_q;
        assign fk[u]       = fk_q;
        assign op[u]       = op_q;
    end
endmodule

// File: rtl/sb_write_arb.sv
// Result-write arbiter: a finished slot is eligible when no other busy slot
// still has a ready, unread source naming its destination; the lowest
// eligible slot wins the single write port. Pure combinational.
module sb_write_arb
    import sb_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [NUM_UNITS-1:0]            done,
    input  logic [NUM_UNITS-1:0]            busy,
    input  logic [NUM_UNITS-1:0]            rj,
    input  logic [NUM_UNITS-1:0]            rk,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] fi,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] fj,
    input  logic [NUM_UNITS-1:0][REG_W-1:0] fk,
    output logic [NUM_UNITS-1:0]            wr_grant,
    output logic                            wr_fire,
    output logic [UNIT_W-1:0]               wr_unit,
    output logic [REG_W-1:0]                wr_dst
);
    logic [NUM_UNITS-1:0] eligible;

    // Write-after-read screen for every finished slot.
    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            eligible[u] = done[u];
            for (int v = 0; v < NUM_UNITS; v++) begin
                if (v != u && busy[v] &&
                    ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
                    eligible[u] = 1'b0;
            end
        end
    end

    // Fixed priority: scanning downward leaves the lowest eligible slot.
    always_comb begin
        wr_grant = '0;
        wr_unit  = UNIT_NONE;
        wr_dst   = '0;
        for (int u = NUM_UNITS - 1; u >= 0; u--) begin
            if (eligible[u]) begin
                wr_grant = NUM_UNITS'(1) << u;
                wr_unit  = UNIT_W'(u);
                wr_dst   = fi[u];
            end
        end
    end

    assign wr_fire = |eligible;
endmodule

// File: rtl/sb_hazard_ctrl.sv
// Top of the scoreboard hazard controller: wires the issue selector,
// register owner table, slot records and write arbiter together.
// Assumes one offered instruction per cycle, held by the source until accepted,
// and one-cycle exec_done pulses from the functional units.
module sb_hazard_ctrl
    import sb_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int OP_W  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic [OP_W-1:0]             iss_op,
    input  logic [REG_W-1:0]            iss_dst,
    input  logic [REG_W-1:0]            iss_src1,
    input  logic [REG_W-1:0]            iss_src2,
    input  logic [1:0]                  iss_class,
    output logic                        iss_accept,
    output logic [2:0]                  iss_unit,
    output logic [4:0]                  rd_grant,
    input  logic [4:0]                  exec_done,
    output logic [4:0]                  wr_grant,
    output logic [REG_W-1:0]            wr_dst,
    output logic [5*OP_W-1:0]           unit_op
);
    logic [NUM_UNITS-1:0]            busy, done, rj, rk, slot_busy;
    logic [NUM_UNITS-1:0][REG_W-1:0] fi, fj, fk;
    logic [NUM_UNITS-1:0][OP_W-1:0]  op_arr;
    logic                            wr_fire, dst_pending;
    logic [UNIT_W-1:0]               wr_unit, slot, owner_a, owner_b;

    // A slot being written this cycle is free for the issuing instruction.
    assign slot_busy = busy & ~wr_grant;
    assign iss_unit  = slot;
    assign unit_op   = op_arr;

    sb_issue_sel u_issue (
        .iss_valid   (iss_valid),
        .iss_class   (iss_class),
        .slot_busy   (slot_busy),
        .dst_pending (dst_pending),
        .slot        (slot),
        .accept      (iss_accept)
    );

    sb_reg_status #(.REG_W(REG_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .wr_dst      (wr_dst),
        .iss_fire    (iss_accept),
        .iss_dst     (iss_dst),
        .iss_unit    (slot),
        .look_a      (iss_src1),
        .look_b      (iss_src2),
        .look_d      (iss_dst),
        .owner_a     (owner_a),
        .owner_b     (owner_b),
        .dst_pending (dst_pending)
    );

    sb_unit_table #(.REG_W(REG_W), .OP_W(OP_W)) u_units (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_fire  (iss_accept),
        .iss_unit  (slot),
        .iss_op    (iss_op),
        .iss_dst   (iss_dst),
        .iss_src1  (iss_src1),
        .iss_src2  (iss_src2),
        .iss_qj    (owner_a),
        .iss_qk    (owner_b),
        .exec_done (exec_done),
        .wr_fire   (wr_fire),
        .wr_unit   (wr_unit),
        .busy      (busy),
        .rd_grant  (rd_grant),
        .done      (done),
        .rj        (rj),
        .rk        (rk),
        .fi        (fi),
        .fj        (fj),
        .fk        (fk),
        .op        (op_arr)
    );

    sb_write_arb #(.REG_W(REG_W)) u_warb (
        .done     (done),
        .busy     (busy),
        .rj       (rj),
        .rk       (rk),
        .fi       (fi),
        .fj       (fj),
        .fk       (fk),
        .wr_grant (wr_grant),
        .wr_fire  (wr_fire),
        .wr_unit  (wr_unit),
        .wr_dst   (wr_dst)
    );
endmodule

// File: rtl/sb_checker.sv
// Checker: protocol properties on the controller's ports, bound to the top.
module sb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       iss_valid,
    input logic [1:0] iss_class,
    input logic       iss_accept,
    input logic [2:0] iss_unit,
    input logic [4:0] rd_grant,
    input logic [4:0] wr_grant
);
    // R9: one result write per cycle.
    a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant));

    // R3: nothing enters without an offer.
    a_r3_accept_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        iss_accept |-> iss_valid);

    // R2: multiply instructions land only in a multiplier slot.
    a_r2_mult_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_accept && iss_class == 2'd1) |-> (iss_unit == 3'd1 || iss_unit == 3'd2));

    // R7: a slot never reads and writes in the same cycle.
    a_r7_read_write_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_grant & wr_grant) == 5'd0);

    for (genvar u = 0; u < 5; u++) begin : g_unit
        // R6: one read grant per issued instruction.
        a_r6_read_once: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant[u] |=> !rd_grant[u]);
        // R9: the slot is free after its write.
        a_r9_write_once: assert property (@(posedge clk) disable iff (!rst_n)
            wr_grant[u] |=> !wr_grant[u]);
    end
endmodule

bind sb_hazard_ctrl sb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_class  (iss_class),
    .iss_accept (iss_accept),
    .iss_unit   (iss_unit),
    .rd_grant   (rd_grant),
    .wr_grant   (wr_grant)
);

// File: tb/sb_hazard_ctrl_tb.sv
module sb_hazard_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int REG_W = 5;
    localparam int OP_W  = 4;
    localparam int NU    = 5;
    localparam int NONE  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [OP_W-1:0]  iss_op = '0;
    logic [REG_W-1:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic [1:0]       iss_class = '0;
    logic [4:0]       exec_done = '0;
    logic             iss_accept;
    logic [2:0]       iss_unit;
    logic [4:0]       rd_grant, wr_grant;
    logic [REG_W-1:0] wr_dst;
    logic [NU*OP_W-1:0] unit_op;

    int checks = 0, errors = 0;

    // Reference model state.
    int m_ph[NU], m_fi[NU], m_fj[NU], m_fk[NU], m_qj[NU], m_qk[NU], m_rj[NU], m_rk[NU];
    int m_rs[32];
    // Last observed outputs.
    int o_acc, o_unit, o_rd, o_wr, o_wd;

    always #(CLK_P/2) clk = ~clk;

    sb_hazard_ctrl #(.REG_W(REG_W), .OP_W(OP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_class(iss_class), .iss_accept(iss_accept), .iss_unit(iss_unit),
        .rd_grant(rd_grant), .exec_done(exec_done), .wr_grant(wr_grant),
        .wr_dst(wr_dst), .unit_op(unit_op)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int u = 0; u < NU; u++) begin
            m_ph[u] = 0; m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0;
            m_qj[u] = NONE; m_qk[u] = NONE; m_rj[u] = 0; m_rk[u] = 0;
        end
        for (int r = 0; r < 32; r++) m_rs[r] = NONE;
    endtask

    function automatic bit war_clear(input int u);
        for (int v = 0; v < NU; v++)
            if (v != u && m_ph[v] != 0 &&
                ((m_rj[v] != 0 && m_fj[v] == m_fi[u]) || (m_rk[v] != 0 && m_fk[v] == m_fi[u])))
                return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; iss_valid = 1'b0; exec_done = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Drive one cycle, compare with the model, then advance the model.
    task automatic step(input bit v, input int d, input int s1, input int s2,
                        input int cls, input int dn);
        int e_rd, e_wr, wu, slot, e_acc, pr_d;
        int old_ph[NU];
        bit f1, f2;
        @(negedge clk);
        iss_valid = v; iss_op = OP_W'(d + cls); iss_dst = REG_W'(d);
        iss_src1 = REG_W'(s1); iss_src2 = REG_W'(s2);
        iss_class = 2'(cls); exec_done = 5'(dn);
        #1;
        e_rd = 0;
        for (int u = 0; u < NU; u++)
            if (m_ph[u] == 1 && m_rj[u] != 0 && m_rk[u] != 0) e_rd |= (1 << u);
        wu = -1;
        for (int u = NU - 1; u >= 0; u--)
            if (m_ph[u] == 3 && war_clear(u)) wu = u;
        e_wr = (wu >= 0) ? (1 << wu) : 0;
        pr_d = (wu >= 0 && m_fi[wu] == d) ? NONE : m_rs[d];
        case (cls)
            0: slot = (m_ph[0] == 0 || wu == 0) ? 0 : NONE;
            1: begin
                f1 = (m_ph[1] == 0 || wu == 1);
                f2 = (m_ph[2] == 0 || wu == 2);
                slot = f1 ? 1 : (f2 ? 2 : NONE);
            end
            2: slot = (m_ph[3] == 0 || wu == 3) ? 3 : NONE;
            default: slot = (m_ph[4] == 0 || wu == 4) ? 4 : NONE;
        endcase
        e_acc = (v && slot != NONE && pr_d == NONE) ? 1 : 0;
        o_acc = int'(iss_accept); o_unit = int'(iss_unit);
        o_rd = int'(rd_grant); o_wr = int'(wr_grant); o_wd = int'(wr_dst);
        chk(o_acc == e_acc, "R3", "iss_accept", o_acc, e_acc);
        if (v) chk(o_unit == slot, "R2", "iss_unit", o_unit, slot);
        chk(o_rd == e_rd, "R5", "rd_grant", o_rd, e_rd);
        chk(o_wr == e_wr, "R8", "wr_grant", o_wr, e_wr);
        if (wu >= 0) chk(o_wd == m_fi[wu], "R9", "wr_dst", o_wd, m_fi[wu]);
        // Advance the model to the state after this edge.
        for (int u = 0; u < NU; u++) old_ph[u] = m_ph[u];
        if (wu >= 0) begin
            for (int u = 0; u < NU; u++) if (u != wu) begin
                if (m_qj[u] == wu) begin m_qj[u] = NONE; m_rj[u] = 1; end
                if (m_qk[u] == wu) begin m_qk[u] = NONE; m_rk[u] = 1; end
            end
            m_ph[wu] = 0; m_rj[wu] = 0; m_rk[wu] = 0; m_qj[wu] = NONE; m_qk[wu] = NONE;
            m_rs[m_fi[wu]] = NONE;
        end
        for (int u = 0; u < NU; u++) begin
            if (e_rd[u]) begin m_rj[u] = 0; m_rk[u] = 0; m_ph[u] = 2; end
            else if (old_ph[u] == 2 && dn[u]) m_ph[u] = 3;
        end
        if (e_acc != 0) begin
            m_ph[slot] = 1; m_fi[slot] = d; m_fj[slot] = s1; m_fk[slot] = s2;
            m_qj[slot] = m_rs[s1]; m_qk[slot] = m_rs[s2];
            m_rj[slot] = (m_qj[slot] == NONE) ? 1 : 0;
            m_rk[slot] = (m_qk[slot] == NONE) ? 1 : 0;
            m_rs[d] = slot;
        end
    endtask

    task automatic idle(input int dn);
        step(1'b0, 0, 0, 0, 0, dn);
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        checks++; errors++;
        $display("FAIL R1 watchdog expired actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));

        // R1: reset state, first offer accepted.
        do_reset();
        step(1'b1, 6, 2, 3, 0, 0);
        chk(o_rd == 0 && o_wr == 0, "R1", "grants after reset", o_rd | o_wr, 0);
        chk(o_acc == 1 && o_unit == 0, "R1", "first issue to integer", o_unit, 0);
        step(1'b1, 0, 6, 4, 1, 0);                 // mult waits on integer slot
        chk(o_rd == 1, "R5", "ready sources read next cycle", o_rd, 1);
        chk(o_unit == 1, "R2", "first multiplier", o_unit, 1);
        step(1'b1, 10, 0, 6, 1, 5'b00001);
        chk(o_unit == 2, "R2", "second multiplier", o_unit, 2);
        chk(o_rd == 0, "R6", "read grant only once", o_rd, 0);
        step(1'b1, 12, 1, 1, 1, 0);
        chk(o_acc == 0 && o_unit == NONE, "R2", "no free multiplier", o_unit, NONE);
        chk(o_wr == 1 && o_wd == 6, "R9", "integer writes r6", o_wd, 6);
        step(1'b1, 12, 1, 1, 1, 0);
        chk(o_rd == 2, "R5", "reader woken after write", o_rd, 2);

        // R7: early exec_done ignored.
        do_reset();
        step(1'b1, 1, 2, 3, 2, 0);
        step(1'b0, 0, 0, 0, 0, 5'b01000);          // slot 3 still waiting: ignored
        idle(0);
        idle(0);
        chk(o_wr == 0, "R7", "done before read ignored", o_wr, 0);
        idle(5'b01000);
        idle(0);
        chk(o_wr == 8, "R7", "write after accepted done", o_wr, 8);

        // R8: write-after-read hold.
        do_reset();
        step(1'b1, 7, 1, 1, 0, 0);                 // int r7
        step(1'b1, 9, 7, 3, 3, 0);                 // div reads r7 (pending), r3
        step(1'b1, 3, 1, 1, 2, 0);                 // add writes r3
        idle(0);
        idle(5'b01000);
        idle(0);
        chk(o_wr == 0, "R8", "add held by unread r3", o_wr, 0);
        idle(5'b00001);
        idle(0);
        chk(o_wr == 1 && o_wd == 7, "R8", "integer writes r7", o_wd, 7);
        chk(o_rd == 0, "R4", "divider waits for producer", o_rd, 0);
        idle(0);
        chk(o_rd == 16 && o_wr == 0, "R8", "divider reads, add still held", o_wr, 0);
        idle(0);
        chk(o_wr == 8, "R8", "add released after read", o_wr, 8);

        // R10 / R3: WAW stall and same-cycle write with issue.
        do_reset();
        step(1'b1, 4, 1, 1, 0, 0);
        step(1'b1, 4, 2, 2, 1, 0);
        chk(o_acc == 0, "R3", "WAW stall", o_acc, 0);
        step(1'b1, 4, 2, 2, 1, 5'b00001);
        chk(o_acc == 0, "R3", "WAW stall held", o_acc, 0);
        step(1'b1, 8, 4, 4, 0, 0);
        chk(o_wr == 1 && o_acc == 1 && o_unit == 0, "R10", "reissue into slot being written", o_acc, 1);
        idle(0);
        chk(o_rd == 1, "R10", "source written same cycle is ready", o_rd, 1);

        // R9: priority between two finishers.
        do_reset();
        step(1'b1, 20, 1, 2, 2, 0);
        step(1'b1, 21, 1, 2, 0, 0);
        idle(0);
        idle(5'b01001);
        idle(0);
        chk(o_wr == 1 && o_wd == 21, "R9", "lower slot writes first", o_wr, 1);
        idle(0);
        chk(o_wr == 8 && o_wd == 20, "R9", "other slot next cycle", o_wr, 8);

        // Random traffic against the model.
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            step($urandom_range(0, 9) < 7, $urandom_range(0, 7), $urandom_range(0, 7),
                 $urandom_range(0, 7), $urandom_range(0, 3), $urandom_range(0, 31));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule